// File: doc/BRIEF.md
# Accumulator Execute Unit with Condition Flags

This block is the execute stage of a small 16-bit accumulator machine. It holds four working registers: the high accumulator half, the low accumulator half and two index registers. It also holds four condition flags and an immediate-extension register. Each cycle that `instValid` is high it accepts one decoded instruction. That instruction is a 4-bit opcode, a 2-bit register or sub-operation field, an 8-bit operand byte, a 16-bit data operand and an unsigned-modifier bit. The block updates its registers and flags at the next rising clock edge.

Arithmetic ops add, add with carry, subtract, subtract with borrow, reverse subtract and compare all update carry, sign, negative and zero. The bitwise ops OR, AND and XOR, and the test op, touch only negative and zero. A one-position shift or rotate works on the 32-bit accumulator pair through carry and changes only the carry flag. A prefix instruction builds a wide immediate 8 bits per step. The next non-prefix instruction consumes that immediate and then clears it. Fetch, address generation, memory, multiply, divide and branching are handled elsewhere. A branch unit reads the flags byte from this block.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset every register, the extension register and all flags are zero. The flags byte is laid out as {4'b0, C, S, N, Z}: C at bit 3, S at bit 2, N at bit 1, Z at bit 0.
- R2: Opcode 3 writes reg+data and opcode 4 writes reg+data+C into the register chosen by `regSel` (0 high accumulator, 1 low accumulator, 2 X, 3 Y). C is the carry out, N is the result's top bit, Z is set for a zero result, and S = N XOR signed overflow.
- R3: Opcode 5 writes reg−data and opcode 6 writes reg−data−C. C is set when a borrow occurs. S, N and Z follow the rule of R2.
- R4: Opcode 7 writes data−reg. C is set on borrow. S, N and Z follow the rule of R2.
- R5: Opcode 8 sets C, S, N and Z exactly as opcode 5 would, and leaves every register unchanged.
- R6: Opcodes 0xB, 0xC and 0xD write reg|data, reg&data and reg^data. They update N and Z only, and C and S keep their values.
- R7: Opcode 9 with `regSel`=2 sets N and Z from the data operand. It changes no register and leaves C and S unchanged.
- R8: Opcode 0xA with `regSel`=0 shifts the pair {high,low} left by one with zero fill. C receives the bit shifted out of the top, and S, N and Z are unchanged.
- R9: Opcode 0xA with `regSel`=1 shifts the pair right by one and C receives bit 0 of the low half. The bit shifted into the top is the old top bit, or zero when `unsignedMod` is high.
- R10: Opcode 0xA with `regSel`=2 rotates the pair left through C, and `regSel`=3 rotates it right through C. Only C changes.
- R11: Opcode 0 with `regSel`=0 and a nonzero `opByte` loads the extension register with (old value << 8) + `opByte`, truncated to 16 bits. No other state changes.
- R12: While the extension register is nonzero, the data operand of the next instruction is ((extension << 8) | dataIn[7:0]) truncated to 16 bits. Any valid non-prefix instruction clears the extension register.
- R13: With `instValid` low nothing changes. Opcodes 0 (non-prefix), 1, 2, 9 with `regSel`≠2, 0xE and 0xF leave the registers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Operation code |
| regSel | input | 2 | Register select or sub-operation |
| opByte | input | 8 | Prefix operand byte |
| dataIn | input | 16 | Data operand |
| unsignedMod | input | 1 | Zero-fill modifier for right shift |
| regAh | output | 16 | High accumulator half |
| regAl | output | 16 | Low accumulator half |
| regX | output | 16 | Index register X |
| regY | output | 16 | Index register Y |
| flags | output | 8 | Flags byte {0,C,S,N,Z} |
| prefixExt | output | 16 | Immediate-extension register |

## Verification
Two functions can share one edge: consuming a pending extension, which both forms the operand and clears the register, and the ALU operation that uses that operand. The bench provokes this with one or two prefixes followed directly by an arithmetic, logic or test op, at random and in directed runs. It also issues carry-consuming ops back to back, so that the flag written at one edge is the carry-in for the next. On every clock a behavioural model predicts every register, the flags byte and the extension value, and the bench compares them all after the edge.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ADD,
    K_SUB,
    K_RSUB,
    K_OR,
    K_AND,
    K_XOR,
    K_PASS
  } aluKind_t;

  typedef struct packed {
    aluKind_t aluKind;
    logic     useCarry;
    logic     regWrite;
    logic     updC;
    logic     updS;
    logic     updNZ;
    logic     shiftEn;
    logic     prefixLoad;
    logic     prefixClear;
  } execStrobes_t;

  localparam logic [3:0] OP_MISC  = 4'h0;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_ADDC  = 4'h4;
  localparam logic [3:0] OP_SUB   = 4'h5;
  localparam logic [3:0] OP_SUBC  = 4'h6;
  localparam logic [3:0] OP_RSUB  = 4'h7;
  localparam logic [3:0] OP_CMP   = 4'h8;
  localparam logic [3:0] OP_GRP9  = 4'h9;
  localparam logic [3:0] OP_SHIFT = 4'hA;
  localparam logic [3:0] OP_OR    = 4'hB;
  localparam logic [3:0] OP_AND   = 4'hC;
  localparam logic [3:0] OP_XOR   = 4'hD;

  localparam logic [1:0] SUB_TEST = 2'd2;

endpackage

// File: rtl/acc_exec_ctrl.sv
module acc_exec_ctrl
  import acc_exec_pkg::*;
#(
  parameter int PFX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [3:0]       opcode,
  input  logic [1:0]       regSel,
  input  logic [PFX_W-1:0] opByte,
  output execStrobes_t     strobes
);

  logic isPrefix;
  assign isPrefix = (opcode == OP_MISC) && (regSel == 2'd0) && (opByte != '0);

  always_comb begin
    strobes = '0;
    strobes.aluKind = K_NONE;
    if (instValid) begin
      strobes.prefixLoad  = isPrefix;
      strobes.prefixClear = !isPrefix;
      unique case (opcode)
        OP_ADD, OP_ADDC: begin
          strobes.aluKind  = K_ADD;
          strobes.useCarry = (opcode == OP_ADDC);
          strobes.regWrite = 1'b1;
          strobes.updC = 1'b1; strobes.updS = 1'b1; strobes.updNZ = 1'b1;
        end
        OP_SUB, OP_SUBC, OP_CMP: begin
          strobes.aluKind  = K_SUB;
          strobes.useCarry = (opcode == OP_SUBC);
          strobes.regWrite = (opcode != OP_CMP);
          strobes.updC = 1'b1; strobes.updS = 1'b1; strobes.updNZ = 1'b1;
        end
        OP_RSUB: begin
          strobes.aluKind  = K_RSUB;
          strobes.regWrite = 1'b1;
          strobes.updC = 1'b1; strobes.updS = 1'b1; strobes.updNZ = 1'b1;
        end
        OP_OR, OP_AND, OP_XOR: begin
          strobes.aluKind  = (opcode == OP_OR)  ? K_OR  :
                             (opcode == OP_AND) ? K_AND : K_XOR;
          strobes.regWrite = 1'b1;
          strobes.updNZ    = 1'b1;
        end
        OP_GRP9: begin
          if (regSel == SUB_TEST) begin
            strobes.aluKind = K_PASS;
            strobes.updNZ   = 1'b1;
          end
        end
        OP_SHIFT: begin
          strobes.shiftEn = 1'b1;
          strobes.updC    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R12: prefix load and prefix clear never coincide
  p_prefix_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.prefixLoad, strobes.prefixClear}) <= 1);

  // R13: no strobe without a valid instruction
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (strobes.regWrite == 1'b0 && strobes.updC == 1'b0 &&
                    strobes.updNZ == 1'b0 && strobes.shiftEn == 1'b0));

  // R8: a shift never also writes a single register
  p_shift_no_regwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.shiftEn, strobes.regWrite}));

endmodule

// File: rtl/acc_exec_dp.sv
module acc_exec_dp
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PFX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  execStrobes_t      strobes,
  input  logic [1:0]        regSel,
  input  logic [PFX_W-1:0]  opByte,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              unsignedMod,
  output logic [DATA_W-1:0] regAh,
  output logic [DATA_W-1:0] regAl,
  output logic [DATA_W-1:0] regX,
  output logic [DATA_W-1:0] regY,
  output logic [7:0]        flags,
  output logic [DATA_W-1:0] prefixExt
);

  localparam int NREG  = 4;
  localparam int MSB   = DATA_W - 1;
  localparam int PAIRW = 2 * DATA_W;
  localparam int IDX_AH = 0;
  localparam int IDX_AL = 1;

  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] extReg;
  logic flagC, flagS, flagN, flagZ;

  // operand formation from pending extension
  logic [DATA_W+PFX_W-1:0] extCat;
  logic [DATA_W-1:0]       operand;
  assign extCat  = {extReg, dataIn[PFX_W-1:0]};
  assign operand = (extReg != '0) ? extCat[DATA_W-1:0] : dataIn;

  // ALU
  logic [DATA_W-1:0] srcReg, aluRes;
  logic [DATA_W:0]   wide;
  logic [DATA_W:0]   cinW;
  logic              aluC, aluV;

  assign srcReg = regFile[regSel];
  assign cinW   = {{DATA_W{1'b0}}, (strobes.useCarry & flagC)};

  always_comb begin
    wide   = '0;
    aluRes = '0;
    aluC   = 1'b0;
    aluV   = 1'b0;
    unique case (strobes.aluKind)
      K_ADD: begin
        wide   = {1'b0, srcReg} + {1'b0, operand} + cinW;
        aluRes = wide[DATA_W-1:0];
        aluC   = wide[DATA_W];
        aluV   = (srcReg[MSB] == operand[MSB]) && (aluRes[MSB] != srcReg[MSB]);
      end
      K_SUB: begin
        wide   = {1'b0, srcReg} - {1'b0, operand} - cinW;
        aluRes = wide[DATA_W-1:0];
        aluC   = wide[DATA_W];
        aluV   = (srcReg[MSB] != operand[MSB]) && (aluRes[MSB] != srcReg[MSB]);
      end
      K_RSUB: begin
        wide   = {1'b0, operand} - {1'b0, srcReg};
        aluRes = wide[DATA_W-1:0];
        aluC   = wide[DATA_W];
        aluV   = (operand[MSB] != srcReg[MSB]) && (aluRes[MSB] != operand[MSB]);
      end
      K_OR:   aluRes = srcReg | operand;
      K_AND:  aluRes = srcReg & operand;
      K_XOR:  aluRes = srcReg ^ operand;
      K_PASS: aluRes = operand;
      default: ;
    endcase
  end

  // 32-bit pair shifter through carry
  logic [PAIRW-1:0] pairIn, pairOut;
  logic             shC, fillBit;
  assign pairIn  = {regFile[IDX_AH], regFile[IDX_AL]};
  assign fillBit = unsignedMod ? 1'b0 : pairIn[PAIRW-1];

  always_comb begin
    unique case (regSel)
      2'd0: begin pairOut = {pairIn[PAIRW-2:0], 1'b0};    shC = pairIn[PAIRW-1]; end
      2'd1: begin pairOut = {fillBit, pairIn[PAIRW-1:1]}; shC = pairIn[0];       end
      2'd2: begin pairOut = {pairIn[PAIRW-2:0], flagC};   shC = pairIn[PAIRW-1]; end
      default: begin pairOut = {flagC, pairIn[PAIRW-1:1]}; shC = pairIn[0];      end
    endcase
  end

  // state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
      extReg <= '0;
      flagC <= 1'b0; flagS <= 1'b0; flagN <= 1'b0; flagZ <= 1'b0;
    end else begin
      if (strobes.regWrite) regFile[regSel] <= aluRes;
      if (strobes.shiftEn) begin
        regFile[IDX_AH] <= pairOut[PAIRW-1:DATA_W];
        regFile[IDX_AL] <= pairOut[DATA_W-1:0];
      end
      if (strobes.updC)  flagC <= strobes.shiftEn ? shC : aluC;
      if (strobes.updS)  flagS <= aluRes[MSB] ^ aluV;
      if (strobes.updNZ) begin
        flagN <= aluRes[MSB];
        flagZ <= (aluRes == '0);
      end
      if (strobes.prefixLoad)
        extReg <= {extReg[DATA_W-PFX_W-1:0], opByte};
      else if (strobes.prefixClear)
        extReg <= '0;
    end
  end

  assign regAh     = regFile[0];
  assign regAl     = regFile[1];
  assign regX      = regFile[2];
  assign regY      = regFile[3];
  assign flags     = {4'b0000, flagC, flagS, flagN, flagZ};
  assign prefixExt = extReg;

  // R5: compare leaves every register alone
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.aluKind == K_SUB && !strobes.regWrite) |=>
      (regAh == $past(regAh) && regAl == $past(regAl) &&
       regX == $past(regX) && regY == $past(regY)));

  // R6: logic ops keep C and S
  p_logic_keeps_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.aluKind inside {K_OR, K_AND, K_XOR}) |=>
      (flags[3:2] == $past(flags[3:2])));

  // R7: test writes no register
  p_test_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.aluKind == K_PASS) |=>
      (regAh == $past(regAh) && regAl == $past(regAl) &&
       regX == $past(regX) && regY == $past(regY) && flags[3:2] == $past(flags[3:2])));

  // R10: shifts and rotates keep S, N, Z and the index registers
  p_shift_only_c_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> ($stable(flags[2:0]) && $stable(regX) && $stable(regY)));

  // R12: a consumed extension is gone after the edge
  p_ext_cleared_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.prefixClear |=> (prefixExt == '0));

  // R11: a prefix load keeps registers and flags
  p_prefix_only_ext_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.prefixLoad |=> ($stable(flags) && $stable(regAh) && $stable(regAl) &&
                            $stable(regX) && $stable(regY)));

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PFX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        regSel,
  input  logic [PFX_W-1:0]  opByte,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              unsignedMod,
  output logic [DATA_W-1:0] regAh,
  output logic [DATA_W-1:0] regAl,
  output logic [DATA_W-1:0] regX,
  output logic [DATA_W-1:0] regY,
  output logic [7:0]        flags,
  output logic [DATA_W-1:0] prefixExt
);

  execStrobes_t strobes;

  acc_exec_ctrl #(.PFX_W(PFX_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .opcode    (opcode),
    .regSel    (regSel),
    .opByte    (opByte),
    .strobes   (strobes)
  );

  acc_exec_dp #(.DATA_W(DATA_W), .PFX_W(PFX_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regSel      (regSel),
    .opByte      (opByte),
    .dataIn      (dataIn),
    .unsignedMod (unsignedMod),
    .regAh       (regAh),
    .regAl       (regAl),
    .regX        (regX),
    .regY        (regY),
    .flags       (flags),
    .prefixExt   (prefixExt)
  );

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  regSel = '0;
  logic [7:0]  opByte = '0;
  logic [15:0] dataIn = '0;
  logic        unsignedMod = 1'b0;
  logic [15:0] regAh, regAl, regX, regY, prefixExt;
  logic [7:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] mReg [4];
  logic [15:0] mExt;
  bit mC, mS, mN, mZ;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .regSel(regSel), .opByte(opByte), .dataIn(dataIn), .unsignedMod(unsignedMod),
    .regAh(regAh), .regAl(regAl), .regX(regX), .regY(regY),
    .flags(flags), .prefixExt(prefixExt)
  );

  function automatic string tagFor(bit v, logic [3:0] op, logic [1:0] rs, logic [7:0] b, logic [15:0] ext);
    if (!v) return "R13";
    if (op == 4'h0 && rs == 2'd0 && b != 8'h00) return "R11";
    if (ext != 16'h0) return "R12";
    case (op)
      4'h3, 4'h4: return "R2";
      4'h5, 4'h6: return "R3";
      4'h7: return "R4";
      4'h8: return "R5";
      4'hB, 4'hC, 4'hD: return "R6";
      4'h9: return (rs == 2'd2) ? "R7" : "R13";
      4'hA: return (rs == 2'd0) ? "R8" : (rs == 2'd1) ? "R9" : "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic compareAll(string tag);
    logic [7:0] expFlags;
    expFlags = {4'b0, mC, mS, mN, mZ};
    checks++;
    if (regAh !== mReg[0] || regAl !== mReg[1] || regX !== mReg[2] || regY !== mReg[3] ||
        flags !== expFlags || prefixExt !== mExt) begin
      failures++;
      $display("FAIL %s: actual ah=%h al=%h x=%h y=%h flags=%h ext=%h expected ah=%h al=%h x=%h y=%h flags=%h ext=%h",
               tag, regAh, regAl, regX, regY, flags, prefixExt,
               mReg[0], mReg[1], mReg[2], mReg[3], expFlags, mExt);
    end
  endtask

  // model of one instruction on the clock edge
  task automatic modelStep(bit v, logic [3:0] op, logic [1:0] rs, logic [7:0] b,
                           logic [15:0] d, bit uns);
    logic [15:0] opnd, a, res;
    logic [31:0] pair;
    int r, ai, di, ci;
    bit ovf;
    if (!v) return;
    if (op == 4'h0 && rs == 2'd0 && b != 8'h00) begin
      mExt = (mExt << 8) + {8'h00, b};
      return;
    end
    opnd = (mExt != 0) ? ((mExt << 8) | {8'h00, d[7:0]}) : d;
    mExt = 16'h0;
    a  = mReg[rs];
    ai = int'(a);
    di = int'(opnd);
    ci = mC ? 1 : 0;
    case (op)
      4'h3, 4'h4: begin
        r = ai + di + ((op == 4'h4) ? ci : 0);
        res = r[15:0];
        ovf = (a[15] == opnd[15]) && (res[15] != a[15]);
        mC = (r > 65535); mN = res[15]; mZ = (res == 0); mS = mN ^ ovf;
        mReg[rs] = res;
      end
      4'h5, 4'h6, 4'h8: begin
        r = ai - di - ((op == 4'h6) ? ci : 0);
        res = r[15:0];
        ovf = (a[15] != opnd[15]) && (res[15] != a[15]);
        mC = (r < 0); mN = res[15]; mZ = (res == 0); mS = mN ^ ovf;
        if (op != 4'h8) mReg[rs] = res;
      end
      4'h7: begin
        r = di - ai;
        res = r[15:0];
        ovf = (a[15] != opnd[15]) && (res[15] != opnd[15]);
        mC = (r < 0); mN = res[15]; mZ = (res == 0); mS = mN ^ ovf;
        mReg[rs] = res;
      end
      4'hB, 4'hC, 4'hD: begin
        res = (op == 4'hB) ? (a | opnd) : (op == 4'hC) ? (a & opnd) : (a ^ opnd);
        mN = res[15]; mZ = (res == 0);
        mReg[rs] = res;
      end
      4'h9: if (rs == 2'd2) begin mN = opnd[15]; mZ = (opnd == 0); end
      4'hA: begin
        pair = {mReg[0], mReg[1]};
        case (rs)
          2'd0: begin mC = pair[31]; pair = pair << 1; end
          2'd1: begin mC = pair[0]; pair = {(uns ? 1'b0 : pair[31]), pair[31:1]}; end
          2'd2: begin ovf = pair[31]; pair = {pair[30:0], mC}; mC = ovf; end
          default: begin ovf = pair[0]; pair = {mC, pair[31:1]}; mC = ovf; end
        endcase
        mReg[0] = pair[31:16];
        mReg[1] = pair[15:0];
      end
      default: ;
    endcase
  endtask

  // drive at the falling edge, model at the rising edge, compare at the next falling edge
  task automatic issue(bit v, logic [3:0] op, logic [1:0] rs, logic [7:0] b,
                       logic [15:0] d, bit uns);
    string tag;
    tag = tagFor(v, op, rs, b, mExt);
    instValid = v; opcode = op; regSel = rs; opByte = b; dataIn = d; unsignedMod = uns;
    @(posedge clk);
    modelStep(v, op, rs, b, d, uns);
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic logic [15:0] pickData();
    int k;
    k = $urandom_range(0, 7);
    case (k)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mReg[i] = 16'h0;
    mExt = 0; mC = 0; mS = 0; mN = 0; mZ = 0;
    repeat (3) @(negedge clk);
    compareAll("R1");              // R1: reset state, flags byte all zero
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2: load registers, signed overflow into the sign bit, destination select
    issue(1, 4'h3, 2'd1, 8'h00, 16'h7FFF, 0);
    issue(1, 4'h3, 2'd1, 8'h00, 16'h0001, 0);
    issue(1, 4'h3, 2'd0, 8'h00, 16'hFFFF, 0);
    issue(1, 4'h3, 2'd0, 8'h00, 16'h0001, 0);   // carry out, zero result
    issue(1, 4'h4, 2'd2, 8'h00, 16'h1234, 0);   // R2 carry-in consumed back to back
    issue(1, 4'h4, 2'd3, 8'h00, 16'hFFFF, 0);
    // R3 borrow chain
    issue(1, 4'h5, 2'd2, 8'h00, 16'h2000, 0);
    issue(1, 4'h6, 2'd3, 8'h00, 16'h0000, 0);
    issue(1, 4'h6, 2'd1, 8'h00, 16'h8000, 0);
    // R4 reverse subtract, R5 compare
    issue(1, 4'h7, 2'd2, 8'h00, 16'h0000, 0);
    issue(1, 4'h8, 2'd2, 8'h00, 16'h7FFF, 0);
    issue(1, 4'h8, 2'd1, 8'h00, 16'h0000, 0);
    // R6 logic keeps C, S
    issue(1, 4'hB, 2'd0, 8'h00, 16'h8000, 0);
    issue(1, 4'hC, 2'd0, 8'h00, 16'h0000, 0);
    issue(1, 4'hD, 2'd3, 8'h00, 16'hFFFF, 0);
    // R7 test
    issue(1, 4'h9, 2'd2, 8'h00, 16'h8000, 0);
    issue(1, 4'h9, 2'd2, 8'h00, 16'h0000, 0);
    // R8, R9, R10 shifts and rotates
    issue(1, 4'h3, 2'd0, 8'h00, 16'h8001, 0);
    issue(1, 4'hA, 2'd0, 8'h00, 16'h0000, 0);
    issue(1, 4'hA, 2'd1, 8'h00, 16'h0000, 0);
    issue(1, 4'hB, 2'd0, 8'h00, 16'h8000, 0);
    issue(1, 4'hA, 2'd1, 8'h00, 16'h0000, 1);   // R9 zero fill
    issue(1, 4'hA, 2'd1, 8'h00, 16'h0000, 0);   // R9 sign copy
    issue(1, 4'hA, 2'd2, 8'h00, 16'h0000, 0);
    issue(1, 4'hA, 2'd3, 8'h00, 16'h0000, 0);
    issue(1, 4'hA, 2'd3, 8'h00, 16'h0000, 0);
    // R11, R12 prefix chain consumed by an add in the same edge it clears
    issue(1, 4'h0, 2'd0, 8'h12, 16'hAAAA, 0);
    issue(1, 4'h0, 2'd0, 8'h34, 16'hAAAA, 0);
    issue(1, 4'h3, 2'd2, 8'h00, 16'hFF56, 0);
    issue(1, 4'h0, 2'd0, 8'h80, 16'h0000, 0);
    issue(1, 4'h9, 2'd2, 8'h00, 16'h0001, 0);   // R12 test sees extended operand
    issue(1, 4'h0, 2'd0, 8'h01, 16'h0000, 0);
    issue(1, 4'h0, 2'd0, 8'h00, 16'h0000, 0);   // R12 plain no-op clears extension
    // R13 idle and no-effect opcodes
    issue(0, 4'h3, 2'd1, 8'h00, 16'h5555, 0);
    issue(1, 4'h1, 2'd1, 8'h00, 16'h5555, 0);
    issue(1, 4'hE, 2'd0, 8'h00, 16'h5555, 0);
    issue(1, 4'hF, 2'd3, 8'h00, 16'h5555, 0);
    issue(1, 4'h9, 2'd3, 8'h00, 16'h5555, 0);
    issue(1, 4'h2, 2'd2, 8'h00, 16'h5555, 0);

    // random mix, prefixes sprinkled in
    for (int n = 0; n < 4000; n++) begin
      bit v;
      logic [3:0] op;
      logic [7:0] b;
      v  = ($urandom_range(0, 15) != 0);
      op = 4'($urandom_range(0, 15));
      b  = 8'($urandom());
      if ($urandom_range(0, 9) == 0) begin op = 4'h0; issue(v, op, 2'd0, b, pickData(), 0); end
      else issue(v, op, 2'($urandom()), b, pickData(), 1'($urandom()));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule